// File: doc/BRIEF.md
# Multi-Format Tester Waveform Formatter

This block shapes one reference data bit per tester cycle into a serial waveform on a single output pin. A set of edge-marker strobes says when the pin may change. Each strobe is a single-cycle enable pulse in the one system clock, not a clock of its own. A 3-bit selector picks how the bit is drawn. The pin can be driven with the data, returned to a fixed level, or driven with the complement of the data at particular markers.

In use, marker 0 opens each tester cycle and captures the data bit and the format. Both stay fixed until the next marker-0 capture. Markers 1 to 4 then place the data window and the return edges that the captured format calls for. Markers 5 and 6 exist for timing sets that other formats use, and they leave this pin untouched. If several markers arrive in the same clock cycle, only the highest-numbered one acts. The output is registered. It changes on the clock edge that samples a marker and is visible in the following cycle.

Top module: `waveform_formatter`

## Requirements
- R1: An active-high synchronous reset drives waveOut to 0 and clears the captured data to 0 and the captured format to NRZ (000). After reset, a marker-1 strobe with no marker-0 strobe before it drives 0.
- R2: A marker-0 strobe (markers bit 0) captures dataIn and fmtSel. Changes on dataIn and fmtSel at any other time have no effect on later markers until the next capture.
- R3: NRZ (fmtSel 000): marker 1 drives the captured data, and markers 0, 2, 3, 4, 5 and 6 leave the output unchanged.
- R4: RTZ (001): marker 1 drives the captured data and marker 2 forces 0.
- R5: RTO (010): marker 1 drives the captured data and marker 2 forces 1.
- R6: SBC (011): marker 0 drives the complement of the incoming data bit, marker 1 drives the data, and marker 2 drives the complement again.
- R7: Double pulse positive (100): markers 1 and 3 drive the data, and markers 2 and 4 force 0. A 1 therefore gives two high pulses and a 0 stays low.
- R8: Double pulse negative (101): markers 1 and 3 drive the complement of the data, and markers 2 and 4 force 1. A 1 therefore gives two low pulses and a 0 stays high.
- R9: Codes 110 and 111 hold the output at its previous level on every marker.
- R10: When several markers are set in one cycle, only the highest-numbered one acts. A lower marker 0 in that cycle therefore captures nothing.
- R11: The output changes only on the clock edge that samples an acting marker, and it is visible in the next cycle. With no markers set, it holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset |
| dataIn | input | 1 | Reference data bit, captured at marker 0 |
| markers | input | NUM_MARKERS | Edge-marker strobes; bit i is marker i |
| fmtSel | input | 3 | Waveform format code, captured at marker 0 |
| waveOut | output | 1 | Formatted serial waveform |

## Verification
The bench builds the block with the default NUM_MARKERS of 7. This brings within reach the two markers that no format uses, so the bench can show that they leave the pin alone. It also allows simultaneous marker pairs such as 0 with 1 and 1 with 2, which exercise the priority rule, including the case where a capture is lost. Every format is run with both data values. The reserved codes and mid-cycle changes on the data and format inputs are also covered.

// File: rtl/wfmt_pkg.sv
package wfmt_pkg;
  localparam int FMT_W = 3;

  typedef enum logic [FMT_W-1:0] {
    FMT_NRZ  = 3'b000,
    FMT_RTZ  = 3'b001,
    FMT_RTO  = 3'b010,
    FMT_SBC  = 3'b011,
    FMT_DPOS = 3'b100,
    FMT_DNEG = 3'b101,
    FMT_RSV6 = 3'b110,
    FMT_RSV7 = 3'b111
  } fmt_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;  // latch the incoming data bit
    logic useIn;    // take the source bit from dataIn instead of the latched bit
    logic setTrue;  // output <= source bit
    logic setComp;  // output <= ~source bit
    logic setZero;  // output <= 0
    logic setOne;   // output <= 1
  } strobe_t;
endpackage

// File: rtl/wfmt_ctrl.sv
module wfmt_ctrl
  import wfmt_pkg::*;
#(
  parameter int NUM_MARKERS = 7
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_MARKERS-1:0] markers,
  input  logic [FMT_W-1:0]       fmtIn,
  output strobe_t                strb
);
  localparam int IDX_W = $clog2(NUM_MARKERS);
  localparam logic [IDX_W-1:0] M0 = IDX_W'(0);
  localparam logic [IDX_W-1:0] M1 = IDX_W'(1);
  localparam logic [IDX_W-1:0] M2 = IDX_W'(2);
  localparam logic [IDX_W-1:0] M3 = IDX_W'(3);
  localparam logic [IDX_W-1:0] M4 = IDX_W'(4);

  fmt_e             fmtReg;
  fmt_e             fmtNew;
  logic             hit;
  logic [IDX_W-1:0] idx;

  assign fmtNew = fmt_e'(fmtIn);

  // Highest-numbered marker wins: later iterations overwrite earlier ones.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < NUM_MARKERS; i++) begin
      if (markers[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    strb = '0;
    if (hit) begin
      unique case (idx)
        M0: begin
          strb.capture = 1'b1;
          if (fmtNew == FMT_SBC) begin
            strb.useIn   = 1'b1;
            strb.setComp = 1'b1;
          end
        end
        M1: begin
          unique case (fmtReg)
            FMT_NRZ, FMT_RTZ, FMT_RTO, FMT_SBC, FMT_DPOS: strb.setTrue = 1'b1;
            FMT_DNEG: strb.setComp = 1'b1;
            default: ;
          endcase
        end
        M2: begin
          unique case (fmtReg)
            FMT_RTZ, FMT_DPOS: strb.setZero = 1'b1;
            FMT_RTO, FMT_DNEG: strb.setOne  = 1'b1;
            FMT_SBC:           strb.setComp = 1'b1;
            default: ;
          endcase
        end
        M3: begin
          if (fmtReg == FMT_DPOS) strb.setTrue = 1'b1;
          if (fmtReg == FMT_DNEG) strb.setComp = 1'b1;
        end
        M4: begin
          if (fmtReg == FMT_DPOS) strb.setZero = 1'b1;
          if (fmtReg == FMT_DNEG) strb.setOne  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) fmtReg <= FMT_NRZ;
    else if (strb.capture) fmtReg <= fmtNew;
  end

  // R2: a capture loads the format that was presented with it
  a_r2_capture_fmt: assert property (@(posedge clk) disable iff (rst)
    strb.capture |=> fmtReg == fmt_e'($past(fmtIn)));

  // R10: any higher marker suppresses the marker-0 capture
  a_r10_capture_lost: assert property (@(posedge clk) disable iff (rst)
    (|markers[NUM_MARKERS-1:1]) |-> !strb.capture);
endmodule

// File: rtl/wfmt_datapath.sv
module wfmt_datapath
  import wfmt_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    dataIn,
  input  strobe_t strb,
  output logic    waveOut
);
  logic dataReg;
  logic srcBit;
  logic anySet;

  assign srcBit = strb.useIn ? dataIn : dataReg;
  assign anySet = strb.setTrue | strb.setComp | strb.setZero | strb.setOne;

  always_ff @(posedge clk) begin
    if (rst) begin
      dataReg <= 1'b0;
      waveOut <= 1'b0;
    end else begin
      if (strb.capture) dataReg <= dataIn;
      if (strb.setTrue)      waveOut <= srcBit;
      else if (strb.setComp) waveOut <= ~srcBit;
      else if (strb.setZero) waveOut <= 1'b0;
      else if (strb.setOne)  waveOut <= 1'b1;
    end
  end

  // R11: at most one output action per cycle
  a_r11_one_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.setTrue, strb.setComp, strb.setZero, strb.setOne}));

  // R11: no action means the pin holds
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !anySet |=> $stable(waveOut));

  // R4: a forced low return lands on the next cycle
  a_r4_force_low: assert property (@(posedge clk) disable iff (rst)
    strb.setZero |=> !waveOut);

  // R5: a forced high return lands on the next cycle
  a_r5_force_high: assert property (@(posedge clk) disable iff (rst)
    strb.setOne |=> waveOut);
endmodule

// File: rtl/waveform_formatter.sv
module waveform_formatter
  import wfmt_pkg::*;
#(
  parameter int NUM_MARKERS = 7
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   dataIn,
  input  logic [NUM_MARKERS-1:0] markers,
  input  logic [FMT_W-1:0]       fmtSel,
  output logic                   waveOut
);
  strobe_t strb;

  wfmt_ctrl #(.NUM_MARKERS(NUM_MARKERS)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .markers(markers),
    .fmtIn  (fmtSel),
    .strb   (strb)
  );

  wfmt_datapath u_dp (
    .clk    (clk),
    .rst    (rst),
    .dataIn (dataIn),
    .strb   (strb),
    .waveOut(waveOut)
  );
endmodule

// File: tb/waveform_formatter_bench.sv
module waveform_formatter_bench;
  localparam int NM = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dataIn = 1'b0;
  logic [NM-1:0] markers = '0;
  logic [2:0]    fmtSel = 3'b000;
  logic          waveOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  waveform_formatter #(.NUM_MARKERS(NM)) u_waveform_formatter (
    .clk(clk), .rst(rst), .dataIn(dataIn), .markers(markers),
    .fmtSel(fmtSel), .waveOut(waveOut)
  );

  task automatic check(input logic exp, input string req);
    checks++;
    if (waveOut !== exp) begin
      failures++;
      $display("FAIL %s: waveOut=%b expected=%b at %0t", req, waveOut, exp, $time);
    end
  endtask

  // Present a marker mask for one cycle; the result is visible after that edge.
  task automatic pulse(input logic [NM-1:0] mask);
    @(negedge clk) markers = mask;
    @(negedge clk) markers = '0;
  endtask

  task automatic pulseChk(input int m, input logic exp, input string req);
    pulse(NM'(1) << m);
    check(exp, req);
  endtask

  task automatic capture(input logic d, input logic [2:0] f);
    @(negedge clk);
    dataIn = d;
    fmtSel = f;
    pulse(NM'(1));
  endtask

  task automatic t_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check(1'b0, "R1 reset level");
    dataIn = 1'b1;
    fmtSel = 3'b011;
    pulseChk(1, 1'b0, "R1 cleared data at marker 1");
  endtask

  task automatic t_nrz();
    capture(1'b1, 3'b000);
    pulseChk(1, 1'b1, "R3 NRZ marker1 d1");
    for (int m = 2; m < NM; m++) pulseChk(m, 1'b1, "R3 NRZ hold");
    capture(1'b0, 3'b000);
    check(1'b1, "R3 NRZ marker0 hold");
    pulseChk(1, 1'b0, "R3 NRZ marker1 d0");
  endtask

  task automatic t_rtz_rto();
    capture(1'b1, 3'b001);
    pulseChk(1, 1'b1, "R4 RTZ marker1");
    pulseChk(2, 1'b0, "R4 RTZ marker2");
    capture(1'b0, 3'b010);
    pulseChk(1, 1'b0, "R5 RTO marker1 d0");
    pulseChk(2, 1'b1, "R5 RTO marker2");
    capture(1'b1, 3'b010);
    pulseChk(1, 1'b1, "R5 RTO marker1 d1");
  endtask

  task automatic t_sbc();
    capture(1'b1, 3'b011);
    check(1'b0, "R6 SBC marker0 d1");
    pulseChk(1, 1'b1, "R6 SBC marker1 d1");
    pulseChk(2, 1'b0, "R6 SBC marker2 d1");
    capture(1'b0, 3'b011);
    check(1'b1, "R6 SBC marker0 d0");
    pulseChk(1, 1'b0, "R6 SBC marker1 d0");
    pulseChk(2, 1'b1, "R6 SBC marker2 d0");
  endtask

  task automatic t_double();
    capture(1'b1, 3'b100);
    pulseChk(1, 1'b1, "R7 DPOS marker1");
    pulseChk(2, 1'b0, "R7 DPOS marker2");
    pulseChk(3, 1'b1, "R7 DPOS marker3");
    pulseChk(4, 1'b0, "R7 DPOS marker4");
    pulseChk(5, 1'b0, "R7 DPOS marker5 no effect");
    capture(1'b1, 3'b101);
    pulseChk(1, 1'b0, "R8 DNEG marker1");
    pulseChk(2, 1'b1, "R8 DNEG marker2");
    pulseChk(3, 1'b0, "R8 DNEG marker3");
    pulseChk(4, 1'b1, "R8 DNEG marker4");
    capture(1'b0, 3'b101);
    pulseChk(1, 1'b1, "R8 DNEG d0 marker1");
    pulseChk(3, 1'b1, "R8 DNEG d0 marker3");
    capture(1'b0, 3'b100);
    pulseChk(1, 1'b0, "R7 DPOS d0 marker1");
    pulseChk(3, 1'b0, "R7 DPOS d0 marker3");
  endtask

  task automatic t_ignore_inputs();
    capture(1'b1, 3'b001);
    @(negedge clk);
    dataIn = 1'b0;
    fmtSel = 3'b010;
    pulseChk(1, 1'b1, "R2 data held after capture");
    pulseChk(2, 1'b0, "R2 format held after capture");
  endtask

  task automatic t_reserved();
    capture(1'b1, 3'b000);
    pulseChk(1, 1'b1, "R9 setup");
    capture(1'b0, 3'b110);
    for (int m = 0; m < NM; m++) pulseChk(m, 1'b1, "R9 code 110 hold");
    capture(1'b0, 3'b001);
    pulseChk(1, 1'b0, "R9 setup low");
    capture(1'b1, 3'b111);
    for (int m = 1; m < NM; m++) pulseChk(m, 1'b0, "R9 code 111 hold");
  endtask

  task automatic t_priority();
    capture(1'b1, 3'b001);
    pulse(7'b0000110);
    check(1'b0, "R10 marker2 beats marker1");
    @(negedge clk);
    dataIn = 1'b0;
    fmtSel = 3'b000;
    pulse(7'b0000011);
    check(1'b1, "R10 marker1 beats marker0, no capture");
    pulseChk(2, 1'b0, "R10 format not recaptured");
    pulse(7'b0010100);
    check(1'b0, "R10 marker4 beats marker2");
  endtask

  task automatic t_idle();
    capture(1'b1, 3'b010);
    pulseChk(1, 1'b1, "R11 setup");
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(1'b1, "R11 idle hold");
    end
    @(negedge clk) markers = 7'b0000100;
    #1 check(1'b1, "R11 not before edge");
    @(negedge clk) markers = '0;
    check(1'b1, "R11 RTO marker2 after edge");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_nrz();
    t_rtz_rto();
    t_sbc();
    t_double();
    t_ignore_inputs();
    t_reserved();
    t_priority();
    t_idle();
    t_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: timeout actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule